// File: doc/BRIEF.md
# Masked Banked Scratchpad Memory

This block is the local scratchpad of one compute unit. It keeps 32-bit words in 32 independent banks and serves one access per request on behalf of a whole wave of lanes. Each lane supplies its own word address and one enable bit. A load fills the result vector only in the enabled lanes. A store writes memory only from the enabled lanes.

A bank can serve one word per cycle. When enabled lanes collide on a bank, the block grants the lowest-numbered waiting lane in that bank and serves the others in later cycles. `busy` is high while lanes remain to be served. A one-cycle `done` pulse marks completion, and `rd_data` is valid from that cycle on. A request is taken on a rising edge where `req_valid` is high and `busy` is low.

Top module: `lmem_banked`

## Requirements
- R1: A word address selects bank `addr[4:0]` and row `addr[7:5]`. A word stored at an address is returned by a later load of that address.
- R2: A load updates `rd_data` lane `l` (bits `32*l+31 : 32*l`) only when `req_mask[l]` is 1. Every other lane keeps its previous value.
- R3: A store changes memory only at the addresses of lanes whose mask bit is 1.
- R4: Each bank serves at most one lane per cycle. With k being the largest number of enabled lanes that share one bank, `done` is high in the cycle after the k-th rising edge that follows the accepting edge.
- R5: A request with an all-zero mask raises `done` in the cycle right after the accepting edge. It changes neither memory nor `rd_data`.
- R6: When several enabled lanes store to the same address, the value of the highest-numbered of those lanes is the one kept.
- R7: `busy` is high from the accepting edge until `done`, and `done` never coincides with `busy`. A request presented while `busy` is high is ignored.
- R8: `rd_data` changes only when a load serves lanes. Stores and idle cycles leave it unchanged.
- R9: After synchronous reset, `busy` and `done` are 0 and `rd_data` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_write | input | 1 | 1 = store, 0 = load |
| req_mask | input | 16 | Per-lane enable |
| req_addr | input | 128 | Lane `l` word address in bits `8*l+7 : 8*l` |
| req_wdata | input | 512 | Lane `l` store word in bits `32*l+31 : 32*l` |
| busy | output | 1 | Lanes of the current request are still pending |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 512 | Per-lane load results, lane `l` in bits `32*l+31 : 32*l` |

## Verification
Two things can fall in the same cycle: the serialisation of a bank conflict, and a new request arriving while that conflict is still being worked off. The bench starts a 16-way same-bank load and, one cycle later, presents a full-mask store to an unrelated address while `busy` is high. It then checks that the load finishes at its expected latency with correct data, and that a later load of the store's address still returns the original word. The same-address store checks the grant order, because only a lowest-lane-first order leaves the highest lane's value in memory.

// File: rtl/lmem_pkg.sv
package lmem_pkg;

    localparam int WORD_W    = 32;
    localparam int DEF_LANES = 16;
    localparam int DEF_BANKS = 32;
    localparam int DEF_DEPTH = 8;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } op_e;

endpackage

// File: rtl/lmem_arbiter.sv
// Per-bank grant: a waiting lane wins unless a lower waiting lane maps to the same bank.
module lmem_arbiter #(
    parameter int LANES  = 16,
    parameter int BANK_W = 5,
    parameter int ADDR_W = 8
) (
    input  logic [LANES-1:0]             pend,
    input  logic [LANES-1:0][ADDR_W-1:0] addr,
    output logic [LANES-1:0]             grant
);

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            grant[l] = pend[l];
            for (int j = 0; j < l; j++) begin
                if (pend[j] && (addr[j][BANK_W-1:0] == addr[l][BANK_W-1:0]))
                    grant[l] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/lmem_xbar.sv
// Steers granted lanes to their banks and bank read words back to lanes.
module lmem_xbar #(
    parameter int LANES  = 16,
    parameter int BANKS  = 32,
    parameter int BANK_W = 5,
    parameter int ROW_W  = 3,
    parameter int ADDR_W = 8,
    parameter int WORD_W = 32
) (
    input  logic [LANES-1:0]             grant,
    input  logic [LANES-1:0][ADDR_W-1:0] addr,
    input  logic [LANES-1:0][WORD_W-1:0] wdata,
    input  logic [BANKS-1:0][WORD_W-1:0] bank_rdata,
    output logic [BANKS-1:0]             bank_en,
    output logic [BANKS-1:0][ROW_W-1:0]  bank_row,
    output logic [BANKS-1:0][WORD_W-1:0] bank_wdata,
    output logic [LANES-1:0][WORD_W-1:0] lane_rdata
);

    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            bank_en[b]    = 1'b0;
            bank_row[b]   = '0;
            bank_wdata[b] = '0;
            for (int l = 0; l < LANES; l++) begin
                if (grant[l] && (addr[l][BANK_W-1:0] == BANK_W'(b))) begin
                    bank_en[b]    = 1'b1;
                    bank_row[b]   = bank_row[b] | addr[l][ADDR_W-1:BANK_W];
                    bank_wdata[b] = bank_wdata[b] | wdata[l];
                end
            end
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++)
            lane_rdata[l] = bank_rdata[addr[l][BANK_W-1:0]];
    end

endmodule

// File: rtl/lmem_bank.sv
// One bank: single port, synchronous write, combinational read.
module lmem_bank #(
    parameter int DEPTH  = 8,
    parameter int ROW_W  = 3,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (en && we)
            store_q[row] <= wdata;
    end

    assign rdata = store_q[row];

endmodule

// File: rtl/lmem_banked.sv
module lmem_banked
    import lmem_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int BANKS = DEF_BANKS,
    parameter int DEPTH = DEF_DEPTH,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ROW_W  = $clog2(DEPTH),
    localparam int ADDR_W = BANK_W + ROW_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [LANES-1:0]         req_mask,
    input  logic [LANES*ADDR_W-1:0]  req_addr,
    input  logic [LANES*WORD_W-1:0]  req_wdata,
    output logic                     busy,
    output logic                     done,
    output logic [LANES*WORD_W-1:0]  rd_data
);

    op_e                            op_q;
    logic                           is_store;
    logic [LANES-1:0]               pend;
    logic [LANES-1:0]               grant;
    logic [LANES-1:0]               pend_next;
    logic [LANES-1:0][ADDR_W-1:0]   addr_q;
    logic [LANES-1:0][WORD_W-1:0]   wdata_q;
    logic [LANES-1:0][WORD_W-1:0]   rd_q;
    logic [LANES-1:0][WORD_W-1:0]   lane_rdata;
    logic [BANKS-1:0]               bank_en;
    logic [BANKS-1:0][ROW_W-1:0]    bank_row;
    logic [BANKS-1:0][WORD_W-1:0]   bank_wdata;
    logic [BANKS-1:0][WORD_W-1:0]   bank_rdata;
    logic                           accept;

    assign is_store  = (op_q == OP_STORE);
    assign busy      = |pend;
    assign accept    = req_valid && !busy;
    assign pend_next = pend & ~grant;
    assign rd_data   = rd_q;

    lmem_arbiter #(
        .LANES (LANES),
        .BANK_W(BANK_W),
        .ADDR_W(ADDR_W)
    ) u_arb (
        .pend (pend),
        .addr (addr_q),
        .grant(grant)
    );

    lmem_xbar #(
        .LANES (LANES),
        .BANKS (BANKS),
        .BANK_W(BANK_W),
        .ROW_W (ROW_W),
        .ADDR_W(ADDR_W),
        .WORD_W(WORD_W)
    ) u_xbar (
        .grant     (grant),
        .addr      (addr_q),
        .wdata     (wdata_q),
        .bank_rdata(bank_rdata),
        .bank_en   (bank_en),
        .bank_row  (bank_row),
        .bank_wdata(bank_wdata),
        .lane_rdata(lane_rdata)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        lmem_bank #(
            .DEPTH (DEPTH),
            .ROW_W (ROW_W),
            .WORD_W(WORD_W)
        ) u_bank (
            .clk  (clk),
            .en   (bank_en[b]),
            .we   (is_store),
            .row  (bank_row[b]),
            .wdata(bank_wdata[b]),
            .rdata(bank_rdata[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= OP_LOAD;
            pend    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rd_q    <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                op_q    <= req_write ? OP_STORE : OP_LOAD;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                pend    <= req_mask;
                if (req_mask == '0)
                    done <= 1'b1;
            end else if (busy) begin
                pend <= pend_next;
                if (pend_next == '0)
                    done <= 1'b1;
                if (!is_store) begin
                    for (int l = 0; l < LANES; l++) begin
                        if (grant[l])
                            rd_q[l] <= lane_rdata[l];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/lmem_banked_chk.sv
module lmem_banked_chk #(
    parameter int LANES  = 16,
    parameter int BANKS  = 32,
    parameter int ADDR_W = 8,
    parameter int WORD_W = 32
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             req_valid,
    input logic                             busy,
    input logic                             done,
    input logic                             is_store,
    input logic [LANES-1:0]                 grant,
    input logic [LANES-1:0][ADDR_W-1:0]     addr_q,
    input logic [LANES*WORD_W-1:0]          rd_data
);

    localparam int BANK_W = $clog2(BANKS);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank_chk
        logic [LANES-1:0] in_bank;
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign in_bank[l] = (addr_q[l][BANK_W-1:0] == BANK_W'(b));
        end
        assert_one_per_bank_R4: assert property (@(posedge clk) disable iff (rst)
            $countones(grant & in_bank) <= 1);
    end

    assert_busy_progress_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (grant != '0));

    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_busy_from_req_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));

    assert_rd_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy || is_store) |=> $stable(rd_data));

endmodule

bind lmem_banked lmem_banked_chk #(
    .LANES (LANES),
    .BANKS (BANKS),
    .ADDR_W(ADDR_W),
    .WORD_W(lmem_pkg::WORD_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .busy     (busy),
    .done     (done),
    .is_store (is_store),
    .grant    (grant),
    .addr_q   (addr_q),
    .rd_data  (rd_data)
);

// File: tb/lmem_banked_test.sv
`timescale 1ns/1ps
module lmem_banked_test;

    localparam int L  = 16;
    localparam int AW = 8;
    localparam int W  = 32;

    typedef struct {
        int                 lat;
        logic [L*W-1:0]     rd;
        string              tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [L-1:0]      req_mask = '0;
    logic [L*AW-1:0]   req_addr = '0;
    logic [L*W-1:0]    req_wdata = '0;
    logic              busy;
    logic              done;
    logic [L*W-1:0]    rd_data;

    int checks = 0;
    int errors = 0;
    int lat_cnt = 0;
    exp_t sb[$];
    logic [W-1:0]       mdl_mem [256];
    logic [L-1:0][W-1:0] mdl_rd = '0;

    always #10 clk = ~clk;

    lmem_banked uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_mask(req_mask), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic logic [W-1:0] fill_val(input int a);
        return 32'h1000_0000 + a * 32'h0001_0101;
    endfunction

    // Latency counter: edges since the accepting edge.
    always @(posedge clk) begin
        if (req_valid && !busy) lat_cnt <= 0;
        else                    lat_cnt <= lat_cnt + 1;
    end

    // Monitor: pops the expected item on each done pulse.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7 done with no request outstanding: actual 1 expected 0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(lat_cnt == e.lat, $sformatf("%s latency actual %0d expected %0d (R4)",
                      e.tag, lat_cnt, e.lat));
                check(rd_data == e.rd, $sformatf("%s rd_data actual %h expected %h",
                      e.tag, rd_data, e.rd));
            end
        end
    end

    task automatic issue(input bit wr, input logic [L-1:0] mask,
                         input logic [L-1:0][AW-1:0] a, input logic [L-1:0][W-1:0] d,
                         input string tag, input bit poke);
        exp_t e;
        int cnt [32];
        int lat = 0;
        foreach (cnt[i]) cnt[i] = 0;
        for (int l = 0; l < L; l++) begin
            if (mask[l]) begin
                cnt[a[l][4:0]]++;
                if (cnt[a[l][4:0]] > lat) lat = cnt[a[l][4:0]];
            end
        end
        for (int l = 0; l < L; l++) begin
            if (mask[l]) begin
                if (wr) mdl_mem[a[l]] = d[l];
                else    mdl_rd[l] = mdl_mem[a[l]];
            end
        end
        e.lat = lat;
        e.rd  = mdl_rd;
        e.tag = tag;
        sb.push_back(e);
        req_valid = 1'b1;
        req_write = wr;
        req_mask  = mask;
        req_addr  = a;
        req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            check(busy == 1'b1, $sformatf("R7 busy during conflict actual %0b expected 1", busy));
            req_valid = 1'b1;
            req_write = 1'b1;
            req_mask  = '1;
            for (int l = 0; l < L; l++) req_addr[l*AW +: AW] = AW'(5);
            req_wdata = {L{32'hDEAD_BEEF}};
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    initial begin
        logic [L-1:0][AW-1:0] a;
        logic [L-1:0][W-1:0]  d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check(busy == 1'b0, $sformatf("R9 busy actual %0b expected 0", busy));
        check(done == 1'b0, $sformatf("R9 done actual %0b expected 0", done));
        check(rd_data == '0, $sformatf("R9 rd_data actual %h expected 0", rd_data));

        // R1/R8: fill all 256 words, conflict-free blocks of 16
        for (int blk = 0; blk < 16; blk++) begin
            for (int l = 0; l < L; l++) begin
                a[l] = AW'(blk * 16 + l);
                d[l] = fill_val(blk * 16 + l);
            end
            issue(1'b1, '1, a, d, "R1 R8 fill store", 1'b0);
        end
        // R1: readback of consecutive and high-row words
        for (int l = 0; l < L; l++) a[l] = AW'(l);
        issue(1'b0, '1, a, d, "R1 load low words", 1'b0);
        for (int l = 0; l < L; l++) a[l] = AW'(240 + l);
        issue(1'b0, '1, a, d, "R1 load high words", 1'b0);
        // R4: all lanes in bank 0
        for (int l = 0; l < L; l++) a[l] = AW'((l * 32) % 256);
        issue(1'b0, '1, a, d, "R4 sixteen-way conflict", 1'b0);
        // R4: two lanes per bank
        for (int l = 0; l < L; l++) a[l] = AW'((l % 8) + 32 * (l / 8) + 64);
        issue(1'b0, '1, a, d, "R4 two-way conflict", 1'b0);
        // R2: partial mask load
        for (int l = 0; l < L; l++) a[l] = AW'(100 + 3 * l);
        issue(1'b0, 16'hA5C3, a, d, "R2 masked load", 1'b0);
        // R3: partial mask store, then full readback
        for (int l = 0; l < L; l++) begin
            a[l] = AW'(200 + l);
            d[l] = 32'h5A5A_0000 + 32'(l);
        end
        issue(1'b1, 16'h0F0F, a, d, "R3 R8 masked store", 1'b0);
        issue(1'b0, '1, a, d, "R3 readback after masked store", 1'b0);
        // R6: same-address store, highest lane kept
        for (int l = 0; l < L; l++) begin
            a[l] = AW'(77);
            d[l] = 32'hC0DE_0000 + 32'(l);
        end
        issue(1'b1, 16'h7FFE, a, d, "R6 same-address store", 1'b0);
        issue(1'b0, '1, a, d, "R6 same-address readback", 1'b0);
        // R5: zero-mask load and store
        for (int l = 0; l < L; l++) begin
            a[l] = AW'(l);
            d[l] = 32'hFFFF_FFFF;
        end
        issue(1'b0, '0, a, d, "R5 zero-mask load", 1'b0);
        issue(1'b1, '0, a, d, "R5 zero-mask store", 1'b0);
        issue(1'b0, '1, a, d, "R5 memory unchanged", 1'b0);
        // R4/R2/R3: mixed patterns
        for (int t = 0; t < 6; t++) begin
            for (int l = 0; l < L; l++) begin
                a[l] = AW'((l * l * 5 + t * 37 + l * 11) % 256);
                d[l] = 32'h7700_0000 + 32'(t * 256 + l);
            end
            issue(t[0], 16'hFFFF ^ 16'(t * 16'h1357), a, d, "R4 mixed pattern", 1'b0);
        end
        // R7: request while busy is ignored
        for (int l = 0; l < L; l++) a[l] = AW'(l * 32 + 1);
        issue(1'b0, '1, a, d, "R7 conflict with poke", 1'b0 == 1'b1 ? 1'b0 : 1'b1);
        for (int l = 0; l < L; l++) a[l] = AW'(5);
        issue(1'b0, 16'h0001, a, d, "R7 poked address untouched", 1'b0);

        repeat (2) @(negedge clk);
        check(sb.size() == 0, $sformatf("R7 outstanding items actual %0d expected 0", sb.size()));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R4 watchdog expired: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule